// File: doc/BRIEF.md
# Programmable Parallel-Panel Write Sequencer

This block turns one accepted request (an address and a data word) into a single write cycle on an 8080-style parallel panel bus. The bus has an address output, an active-low chip select, an active-low write strobe and a data bus. Four 4-bit timing values set how long each phase of the cycle lasts. A value N always gives N+1 clock cycles, so a value of zero still gives one cycle. In order, the phases are: address-to-select lead, select-to-strobe lead, strobe width, and strobe-to-deselect tail. The clock of the block is the internal video clock that all of these counts refer to.

Requests arrive on a valid/ready handshake. Back-pressure rules: `req_ready` is high only while the sequencer is idle. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. From that edge until chip select has been released, `req_ready` stays low. While it is low, `req_valid`, `req_addr` and `req_data` are ignored. A source that holds `req_valid` high gets transfers back to back, with chip select high for at least one cycle between them. The timing inputs are sampled only at acceptance.

A data-enable output marks the window in which the data bus carries the word. A video-clock output toggles on every clock cycle. Each of these two outputs has its own polarity-inversion input.

Top module: `i80_wr_seq`

## Requirements
- R1: `req_ready` is 1 only when idle. A request is accepted on a rising edge with `req_valid`=1 and `req_ready`=1. `req_ready` then stays 0 until the first cycle after chip select has been released, and requests presented while it is 0 have no effect on the bus.
- R2: After acceptance, `bus_cs_n` stays 1 for exactly `cfg_cs_setup`+1 cycles, with `bus_addr` already showing the accepted address. It then goes to 0.
- R3: After `bus_cs_n` falls, `bus_we_n` stays 1 for exactly `cfg_wr_setup`+1 cycles and then goes to 0.
- R4: `bus_we_n` stays 0 for exactly `cfg_wr_active`+1 cycles. It is never 0 while `bus_cs_n` is 1.
- R5: After `bus_we_n` returns to 1, `bus_cs_n` stays 0 for exactly `cfg_wr_hold`+1 cycles and then returns to 1.
- R6: The four timing inputs are sampled only on the acceptance edge. Changing them during a transfer does not alter that transfer.
- R7: `xfer_done` is 1 for exactly one cycle: the first cycle in which `bus_cs_n` is back at 1. With `req_valid` held at 1, `bus_cs_n` stays high for `cfg_cs_setup`+3 cycles between transfers.
- R8: `bus_addr` holds the accepted address for the whole transfer. `bus_data` shows the accepted word from the first strobe cycle through the `xfer_done` cycle, and is 0 at other times.
- R9: `bus_den` is 1 exactly in the window where data is shown (strobe, tail and done cycles), XORed with `cfg_inv_den`.
- R10: `bus_vclk` toggles on every clock cycle. It is 0 XOR `cfg_inv_clk` during reset, and follows `cfg_inv_clk` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal video clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, can accept |
| req_addr | input | AW | Address of the write |
| req_data | input | DW | Data word of the write |
| cfg_cs_setup | input | 4 | Address-to-select lead, N+1 cycles |
| cfg_wr_setup | input | 4 | Select-to-strobe lead, N+1 cycles |
| cfg_wr_active | input | 4 | Strobe width, N+1 cycles |
| cfg_wr_hold | input | 4 | Strobe-to-deselect tail, N+1 cycles |
| cfg_inv_den | input | 1 | Invert data-enable output |
| cfg_inv_clk | input | 1 | Invert video-clock output |
| bus_addr | output | AW | Panel address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_data | output | DW | Panel data |
| bus_den | output | 1 | Data-enable, polarity per cfg_inv_den |
| bus_vclk | output | 1 | Video clock out, polarity per cfg_inv_clk |
| xfer_done | output | 1 | One-cycle pulse at select release |

## Verification
The bench sweeps the cross product of four values (0, 1, 5 and 15) over all four timing fields and measures the length of every phase. A design that counts N cycles instead of N+1, or that loses the zero-value cycle, gives phases that are one cycle short. In the middle of each transfer, the bench inverts the timing inputs and offers a second request. A design that reads the timing live would stretch the phase, and one that ignores back-pressure would change the address or data on the bus. Held-valid back-to-back traffic shows whether a design merges transfers or drops the idle gap. The polarity inputs are flipped between transfers, which exposes an enable or clock output that ignores its inversion.

// File: rtl/i80_seq_pkg.sv
package i80_seq_pkg;
  localparam int TIME_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LEAD, PH_SEL, PH_STROBE, PH_TAIL, PH_DONE
  } phase_e;

  typedef struct packed {
    logic [TIME_W-1:0] lead;
    logic [TIME_W-1:0] sel;
    logic [TIME_W-1:0] strobe;
    logic [TIME_W-1:0] tail;
  } timing_t;

  localparam timing_t TIMING_RST = '{lead: 0, sel: 0, strobe: 1, tail: 0};
endpackage

// File: rtl/i80_phase_ctr.sv
module i80_phase_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/i80_seq_fsm.sv
module i80_seq_fsm
  import i80_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  timing_t             cfg,
  input  logic                ctr_zero,
  output phase_e              phase,
  output logic                accept,
  output logic                ctr_load,
  output logic [TIME_W-1:0]   ctr_val
);
  phase_e  phase_q, phase_d;
  timing_t tim_q;

  assign accept = req_valid && (phase_q == PH_IDLE);

  always_comb begin
    phase_d  = phase_q;
    ctr_load = 1'b0;
    ctr_val  = '0;
    unique case (phase_q)
      PH_IDLE: if (accept) begin
        phase_d = PH_LEAD; ctr_load = 1'b1; ctr_val = cfg.lead;
      end
      PH_LEAD: if (ctr_zero) begin
        phase_d = PH_SEL; ctr_load = 1'b1; ctr_val = tim_q.sel;
      end
      PH_SEL: if (ctr_zero) begin
        phase_d = PH_STROBE; ctr_load = 1'b1; ctr_val = tim_q.strobe;
      end
      PH_STROBE: if (ctr_zero) begin
        phase_d = PH_TAIL; ctr_load = 1'b1; ctr_val = tim_q.tail;
      end
      PH_TAIL: if (ctr_zero) phase_d = PH_DONE;
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tim_q   <= TIMING_RST;
    end else begin
      phase_q <= phase_d;
      if (accept) tim_q <= cfg;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/i80_pin_drv.sv
module i80_pin_drv
  import i80_seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] data_q,
  input  logic          inv_den,
  input  logic          inv_clk,
  output logic [AW-1:0] bus_addr,
  output logic          bus_cs_n,
  output logic          bus_we_n,
  output logic [DW-1:0] bus_data,
  output logic          bus_den,
  output logic          bus_vclk,
  output logic          ready,
  output logic          done
);
  logic tgl_q;
  logic show;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= ~tgl_q;
  end

  assign show     = (phase == PH_STROBE) || (phase == PH_TAIL) || (phase == PH_DONE);
  assign bus_addr = addr_q;
  assign bus_cs_n = !((phase == PH_SEL) || (phase == PH_STROBE) || (phase == PH_TAIL));
  assign bus_we_n = (phase != PH_STROBE);
  assign bus_data = show ? data_q : '0;
  assign bus_den  = show ^ inv_den;
  assign bus_vclk = tgl_q ^ inv_clk;
  assign ready    = (phase == PH_IDLE);
  assign done     = (phase == PH_DONE);
endmodule

// File: rtl/i80_wr_seq.sv
module i80_wr_seq
  import i80_seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_data,
  input  logic [TIME_W-1:0] cfg_cs_setup,
  input  logic [TIME_W-1:0] cfg_wr_setup,
  input  logic [TIME_W-1:0] cfg_wr_active,
  input  logic [TIME_W-1:0] cfg_wr_hold,
  input  logic              cfg_inv_den,
  input  logic              cfg_inv_clk,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_cs_n,
  output logic              bus_we_n,
  output logic [DW-1:0]     bus_data,
  output logic              bus_den,
  output logic              bus_vclk,
  output logic              xfer_done
);
  timing_t             cfg;
  phase_e              phase;
  logic                accept, ctr_load, ctr_zero;
  logic [TIME_W-1:0]   ctr_val;
  logic [AW-1:0]       addr_q;
  logic [DW-1:0]       data_q;

  assign cfg = '{lead: cfg_cs_setup, sel: cfg_wr_setup,
                 strobe: cfg_wr_active, tail: cfg_wr_hold};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  i80_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cfg(cfg),
    .ctr_zero(ctr_zero), .phase(phase), .accept(accept),
    .ctr_load(ctr_load), .ctr_val(ctr_val)
  );

  i80_phase_ctr #(.W(TIME_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(ctr_val),
    .zero(ctr_zero)
  );

  i80_pin_drv #(.AW(AW), .DW(DW)) drv_i (
    .clk(clk), .rst_n(rst_n), .phase(phase), .addr_q(addr_q),
    .data_q(data_q), .inv_den(cfg_inv_den), .inv_clk(cfg_inv_clk),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n),
    .bus_data(bus_data), .bus_den(bus_den), .bus_vclk(bus_vclk),
    .ready(req_ready), .done(xfer_done)
  );
endmodule

// File: rtl/i80_wr_seq_chk.sv
module i80_wr_seq_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          bus_cs_n,
  input logic          bus_we_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_data,
  input logic          xfer_done
);
  AST_STROBE_IN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> !bus_cs_n);                                       // R4
  AST_READY_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_cs_n && !xfer_done);                          // R1
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> bus_cs_n && !$past(bus_cs_n));                    // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done && req_ready);                         // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> $stable(bus_addr));       // R8
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we_n && $past(!bus_we_n)) |-> $stable(bus_data));         // R8
  AST_CS_FALL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |-> bus_we_n);                                  // R3
endmodule

bind i80_wr_seq i80_wr_seq_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_cs_n(bus_cs_n),
  .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_data(bus_data),
  .xfer_done(xfer_done)
);

// File: tb/i80_wr_seq_tb_top.sv
module i80_wr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [3:0] cfg_cs_setup = 0, cfg_wr_setup = 0, cfg_wr_active = 1, cfg_wr_hold = 0;
  logic cfg_inv_den = 1'b0, cfg_inv_clk = 1'b0;
  logic [AW-1:0] bus_addr;
  logic bus_cs_n, bus_we_n, bus_den, bus_vclk, xfer_done;
  logic [DW-1:0] bus_data;

  int checks = 0;
  int errors = 0;
  bit timed_out = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i80_wr_seq #(.AW(AW), .DW(DW)) dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", req, act, exp);
    end
  endtask

  function automatic int pick(input int i);
    return (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 5 : 15;
  endfunction

  task automatic run_xfer(input int c, input int s, input int a, input int h,
                          input logic [AW-1:0] ad, input logic [DW-1:0] dt,
                          input bit inv);
    int n[5];
    int ph, bad_addr, bad_data, bad_den, bad_ready, bad_order;
    n = '{0, 0, 0, 0, 0};
    bad_addr = 0; bad_data = 0; bad_den = 0; bad_ready = 0; bad_order = 0;
    ph = 0;
    while (!req_ready) @(negedge clk);
    cfg_cs_setup = 4'(c); cfg_wr_setup = 4'(s);
    cfg_wr_active = 4'(a); cfg_wr_hold = 4'(h);
    cfg_inv_den = inv;
    req_addr = ad; req_data = dt; req_valid = 1'b1;
    @(negedge clk);
    // busy now: alter timing and offer a conflicting request (R6, R1)
    cfg_cs_setup = ~4'(c); cfg_wr_setup = ~4'(s);
    cfg_wr_active = ~4'(a); cfg_wr_hold = ~4'(h);
    req_addr = ~ad; req_data = ~dt;
    for (int k = 0; k < 200; k++) begin
      int cur;
      bit show;
      if (xfer_done) cur = 4;
      else if (bus_cs_n && bus_we_n) cur = 0;
      else if (!bus_cs_n && bus_we_n) cur = (ph >= 2) ? 3 : 1;
      else cur = 2;
      if (cur < ph) bad_order++;
      ph = cur;
      n[cur]++;
      show = (cur >= 2);
      if (bus_addr !== ad) bad_addr++;
      if (bus_data !== (show ? dt : '0)) bad_data++;
      if (bus_den !== (show ^ inv)) bad_den++;
      if (req_ready) bad_ready++;
      if (cur == 4) begin
        req_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
    check(n[0] == c + 1, "R2 lead length", n[0], c + 1);
    check(n[1] == s + 1, "R3 select-to-strobe length", n[1], s + 1);
    check(n[2] == a + 1, "R4 strobe width", n[2], a + 1);
    check(n[3] == h + 1, "R5 tail length", n[3], h + 1);
    check(n[4] == 1 && bad_order == 0, "R7 done once after release (R6 order)", n[4], 1);
    check(bad_addr == 0 && bad_data == 0, "R8 address/data mismatches", bad_addr + bad_data, 0);
    check(bad_den == 0, "R9 enable mismatches", bad_den, 0);
    check(bad_ready == 0, "R1 ready while busy", bad_ready, 0);
    @(negedge clk);
    check(req_ready && bus_cs_n && !xfer_done, "R7 idle after done", req_ready, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    timed_out = 1;
  end

  initial begin : stim
    bit v0;
    int gap;
    #(CLK_PERIOD*2);
    // reset state
    check(bus_cs_n && bus_we_n && !xfer_done, "R1 reset bus idle", bus_cs_n, 1);
    check(bus_den == 1'b0 && bus_data == '0, "R9 reset enable", bus_den, 0);
    check(bus_vclk == 1'b0, "R10 reset clock out", bus_vclk, 0);
    cfg_inv_clk = 1'b1; #1;
    check(bus_vclk == 1'b1, "R10 reset clock inverted", bus_vclk, 1);
    cfg_inv_clk = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

    // R10 toggling and live inversion
    v0 = bus_vclk;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(bus_vclk != v0, "R10 toggle each cycle", bus_vclk, !v0);
      v0 = bus_vclk;
    end
    cfg_inv_clk = 1'b1; #1;
    check(bus_vclk != v0, "R10 inversion follows input", bus_vclk, !v0);

    // sweep of timing cross product
    for (int i = 0; i < 256; i++) begin
      if (timed_out) break;
      run_xfer(pick(i & 3), pick((i >> 2) & 3), pick((i >> 4) & 3), pick((i >> 6) & 3),
               AW'(i * 37 + 5), DW'(i * 1021 + 77), i[0]);
    end

    // R7 back-to-back with valid held
    @(negedge clk);
    cfg_cs_setup = 0; cfg_wr_setup = 0; cfg_wr_active = 0; cfg_wr_hold = 0;
    cfg_inv_den = 1'b0;
    req_valid = 1'b1; req_addr = 8'h3C; req_data = 16'hBEEF;
    while (bus_cs_n) @(negedge clk);
    while (!bus_cs_n) @(negedge clk);
    gap = 0;
    while (bus_cs_n && gap < 100) begin gap++; @(negedge clk); end
    check(gap == 3, "R7 select high gap back-to-back", gap, 3);
    check(bus_addr == 8'h3C, "R8 address in held-valid run", bus_addr, 8'h3C);
    req_valid = 1'b0;
    repeat (8) @(negedge clk);

    if (timed_out) check(0, "watchdog", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule